// File: doc/BRIEF.md
# Greyscale Contrast-Stretch Memory Engine

This block rescales the grey levels of an 8-bit greyscale image that sits in a single-port, byte-wide RAM. A start pulse makes it read a two-byte header holding the image width and height. It then reads every pixel once to find the darkest and brightest values. From that range it derives a left-shift amount. A second pass reads each pixel again, subtracts the darkest value, shifts the result, clamps it to 255 and writes it to an output region of the same RAM. When the last pixel is written, done rises.

All traffic uses one port with a single enable and a write strobe. RAM reads have one cycle of latency. Done stays high while start is held. Once start is released the engine returns to idle, and it can take the next image without a reset.

Top module: `stretch_engine`

## Requirements
- R1: While reset (active high, asynchronous) is asserted, and right after it is released, done, mem_en and mem_we are all 0.
- R2: After start, the engine reads address 0 (width C) and then address 1 (height R). Input pixel k (0 ≤ k < R·C, row-major order) is taken from address 2+k.
- R3: Output pixel k is written to address 2+R·C+k, and to no other address. mem_we is only ever high together with mem_en.
- R4: Each output pixel is min(255, (p − lo) << s). Here lo and hi are the darkest and brightest pixel values of the image, and s = 8 − floor(log2(hi − lo + 1)).
- R5: When every pixel has the same value (hi = lo, so s = 8), every output pixel is 0.
- R6: When the image contains both 0 and 255 (s = 0), every output pixel equals its input value.
- R7: When the shifted difference exceeds 255, the output pixel is exactly 255.
- R8: When C or R is 0, no pixel is read and nothing is written. Done rises on the 4th rising edge, counting the edge that first samples start high as the 1st.
- R9: Done stays high for as long as start is held. It falls at the first rising edge after start is sampled low. A further image then runs correctly with no reset in between.
- R10: The input region (addresses 0 to R·C+1) holds the same contents after a run as before it.
- R11: For N = R·C > 0, done rises on rising edge 6 + 3·N, counted as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Begins a run when high in idle; releases done when low |
| rd_data | input | 8 | Read data from the RAM, valid one cycle after a read address |
| mem_addr | output | 16 | RAM address |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | 1 = write, 0 = read |
| wr_data | output | 8 | Byte written to the RAM |
| done | output | 1 | Run finished |

## Verification
Done is due on rising edge 6+3·N after start is first sampled, or on edge 4 for an empty image. The bench counts rising edges from the start edge and reads done at the falling edge that follows each one, so it checks the exact edge rather than a window. The RAM model returns read data one edge after the address, and each output byte is written on the edge after its pixel was read. The bench therefore compares the output region only once done is seen. It checks that done falls one edge after start is dropped, and checks stray writes cycle by cycle through a write monitor on the RAM port.

// File: rtl/stretch_pkg.sv
package stretch_pkg;

    localparam int PIX_W     = 8;
    localparam int ADDR_W    = 16;
    localparam int CNT_W     = ADDR_W;
    localparam int WIDE_W    = 2 * PIX_W;
    localparam int SHF_W     = $clog2(PIX_W + 1);
    localparam int HDR_WORDS = 2;
    localparam int PIX_MAX   = (1 << PIX_W) - 1;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [SHF_W-1:0]  shf_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR_C,
        ST_HDR_R,
        ST_SIZE,
        ST_SCAN,
        ST_TAIL,
        ST_SHIFT,
        ST_RD,
        ST_WR,
        ST_DONE
    } state_t;

    typedef struct packed {
        pix_t lo;
        pix_t hi;
    } range_t;

    // shift = width - index of the top set bit of (hi - lo + 1)
    function automatic shf_t shift_for(input pix_t lo, input pix_t hi);
        logic [PIX_W:0] span;
        shf_t msb;
        span = {1'b0, hi} - {1'b0, lo} + {{PIX_W{1'b0}}, 1'b1};
        msb  = '0;
        for (int i = 0; i <= PIX_W; i++) begin
            if (span[i]) msb = shf_t'(i);
        end
        return shf_t'(PIX_W) - msb;
    endfunction

    function automatic pix_t stretch(input pix_t p, input pix_t lo, input shf_t sh);
        pix_t diff;
        logic [WIDE_W-1:0] wide;
        diff = p - lo;
        wide = {{(WIDE_W-PIX_W){1'b0}}, diff} << sh;
        if (wide > WIDE_W'(PIX_MAX)) return pix_t'(PIX_MAX);
        return wide[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/stretch_ctrl.sv
module stretch_ctrl
    import stretch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   size_zero,
    input  logic   scan_last,
    input  logic   map_last,
    output state_t state
);

    state_t nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (start) nxt = ST_HDR_C;
            ST_HDR_C: nxt = ST_HDR_R;
            ST_HDR_R: nxt = ST_SIZE;
            ST_SIZE:  nxt = size_zero ? ST_DONE : ST_SCAN;
            ST_SCAN:  if (scan_last) nxt = ST_TAIL;
            ST_TAIL:  nxt = ST_SHIFT;
            ST_SHIFT: nxt = ST_RD;
            ST_RD:    nxt = ST_WR;
            ST_WR:    nxt = map_last ? ST_DONE : ST_RD;
            ST_DONE:  if (!start) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && start) |=> (state == ST_DONE)); // R9

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !start) |=> (state == ST_IDLE)); // R9

endmodule

// File: rtl/stretch_range.sv
module stretch_range
    import stretch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   init,
    input  logic   sample,
    input  pix_t   pix,
    output range_t rng
);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rng.lo <= pix_t'(PIX_MAX);
            rng.hi <= '0;
        end else if (init) begin
            rng.lo <= pix_t'(PIX_MAX);
            rng.hi <= '0;
        end else if (sample) begin
            if (pix < rng.lo) rng.lo <= pix;
            if (pix > rng.hi) rng.hi <= pix;
        end
    end

    AST_RANGE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (sample && !init) |=> (rng.lo <= rng.hi)); // R4

    AST_RANGE_COVERS: assert property (@(posedge clk) disable iff (rst)
        (sample && !init) |=> (rng.lo <= $past(pix) && rng.hi >= $past(pix))); // R4

endmodule

// File: rtl/stretch_map.sv
module stretch_map
    import stretch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  range_t rng,
    input  pix_t   pix,
    output pix_t   pix_out
);

    shf_t shift_q;
    pix_t lo_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            shift_q <= '0;
            lo_q    <= '0;
        end else if (load) begin
            shift_q <= shift_for(rng.lo, rng.hi);
            lo_q    <= rng.lo;
        end
    end

    assign pix_out = stretch(pix, lo_q, shift_q);

    AST_SHIFT_BOUND: assert property (@(posedge clk) disable iff (rst)
        load |=> (shift_q <= shf_t'(PIX_W))); // R4

    AST_ZERO_AT_MIN: assert property (@(posedge clk) disable iff (rst)
        (!load && pix == lo_q) |-> (pix_out == '0)); // R4

endmodule

// File: rtl/stretch_engine.sv
module stretch_engine
    import stretch_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [PIX_W-1:0]    rd_data,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_en,
    output logic                mem_we,
    output logic [PIX_W-1:0]    wr_data,
    output logic                done
);

    localparam addr_t HDR_BASE = addr_t'(HDR_WORDS);

    state_t state;
    cnt_t   idx;
    cnt_t   npix;
    pix_t   cols_q;
    logic   rd_v;
    range_t rng;
    pix_t   mapped;
    cnt_t   area;
    logic   size_zero;
    logic   at_last;

    assign area      = cols_q * rd_data;
    assign size_zero = (area == '0);
    assign at_last   = (idx == npix - cnt_t'(1));

    stretch_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .size_zero (size_zero),
        .scan_last (at_last),
        .map_last  (at_last),
        .state     (state)
    );

    stretch_range u_range (
        .clk    (clk),
        .rst    (rst),
        .init   (state == ST_SIZE),
        .sample (rd_v),
        .pix    (rd_data),
        .rng    (rng)
    );

    stretch_map u_map (
        .clk     (clk),
        .rst     (rst),
        .load    (state == ST_SHIFT),
        .rng     (rng),
        .pix     (rd_data),
        .pix_out (mapped)
    );

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            idx    <= '0;
            npix   <= '0;
            cols_q <= '0;
            rd_v   <= 1'b0;
        end else begin
            rd_v <= (state == ST_SCAN);
            case (state)
                ST_HDR_R: cols_q <= rd_data;
                ST_SIZE: begin
                    npix <= area;
                    idx  <= '0;
                end
                ST_SCAN:  idx <= idx + cnt_t'(1);
                ST_SHIFT: idx <= '0;
                ST_WR:    idx <= idx + cnt_t'(1);
                default:  ;
            endcase
        end
    end

    always_comb begin
        mem_addr = '0;
        mem_en   = 1'b0;
        mem_we   = 1'b0;
        case (state)
            ST_HDR_C: begin
                mem_en   = 1'b1;
                mem_addr = '0;
            end
            ST_HDR_R: begin
                mem_en   = 1'b1;
                mem_addr = addr_t'(1);
            end
            ST_SCAN, ST_RD: begin
                mem_en   = 1'b1;
                mem_addr = HDR_BASE + idx;
            end
            ST_WR: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = HDR_BASE + idx + npix;
            end
            default: ;
        endcase
    end

    assign wr_data = mapped;
    assign done    = (state == ST_DONE);

    AST_WE_HAS_EN: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_en); // R3

    AST_WR_REGION: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr >= HDR_BASE + npix && mem_addr < HDR_BASE + npix + npix)); // R3

    AST_RD_REGION: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |-> (mem_addr < HDR_BASE + npix || state == ST_HDR_C || state == ST_HDR_R)); // R10

    AST_FLAT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mem_we && rng.lo == rng.hi) |-> (wr_data == '0)); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_en); // R8

endmodule

// File: tb/test_stretch_engine.sv
`timescale 1ns/1ps
module test_stretch_engine;

    localparam int MEM_D = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] rd_data;
    logic [15:0] mem_addr;
    logic       mem_en, mem_we, done;
    logic [7:0] wr_data;

    logic [7:0] mem [MEM_D];
    logic [7:0] img [2048];
    logic [7:0] snap [MEM_D];
    logic       tb_wr = 1'b0;
    int         tb_a = 0;
    logic [7:0] tb_d = '0;
    int         cur_np = 0;
    int         wr_cnt = 0;
    int         stray = 0;
    int         total = 0;
    int         bad = 0;
    bit         finished = 0;

    always #4 clk = ~clk;

    stretch_engine i_stretch_engine (
        .clk(clk), .rst(rst), .start(start), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we),
        .wr_data(wr_data), .done(done)
    );

    always @(posedge clk) begin
        if (tb_wr) mem[tb_a] <= tb_d;
        else if (mem_en) begin
            if (int'(mem_addr) >= MEM_D) stray <= stray + 1;
            else if (mem_we) begin
                mem[mem_addr] <= wr_data;
                wr_cnt <= wr_cnt + 1;
                if (int'(mem_addr) < 2 + cur_np || int'(mem_addr) >= 2 + 2*cur_np)
                    stray <= stray + 1;
            end else rd_data <= mem[mem_addr];
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_shift(input int delta);
        int lg = 0;
        while ((2 << lg) <= delta + 1) lg++;
        return 8 - lg;
    endfunction

    function automatic int exp_pix(input int p, input int lo, input int s);
        int v = (p - lo) << s;
        return (v > 255) ? 255 : v;
    endfunction

    task automatic poke(input int a, input int d);
        @(negedge clk);
        tb_wr = 1'b1; tb_a = a; tb_d = 8'(d);
        @(negedge clk);
        tb_wr = 1'b0;
    endtask

    // mode 0: random in [base, base+span]; 1: flat; 2: force 0 and 255 present
    task automatic run_image(input int c, input int r, input int base, input int span,
                             input int mode, input string tag);
        int n = c * r;
        int lo = 255, hi = 0, s, edges, mism, first_a, first_e, inchg;
        for (int k = 0; k < n; k++) begin
            if (mode == 1) img[k] = 8'(base);
            else img[k] = 8'(base + int'($urandom % (span + 1)));
        end
        if (mode == 2 && n >= 2) begin img[0] = 8'd0; img[n-1] = 8'd255; end
        poke(0, c); poke(1, r);
        for (int k = 0; k < n; k++) poke(2 + k, img[k]);
        for (int k = 0; k < n; k++) poke(2 + n + k, 8'hA5);
        poke(2 + 2*n, 8'h3C);
        for (int k = 0; k < n; k++) begin
            if (img[k] < lo) lo = img[k];
            if (img[k] > hi) hi = img[k];
        end
        s = exp_shift(hi - lo);
        for (int a = 0; a < 2 + 2*n + 1; a++) snap[a] = mem[a];
        cur_np = n; wr_cnt = 0; stray = 0;
        @(negedge clk);
        start = 1'b1;
        edges = 0;
        do begin
            @(posedge clk); edges++;
            @(negedge clk);
        end while (!done && edges < 60000);
        // R11 / R8: done edge
        if (n == 0) chk(edges == 4, {tag, " R8 done edge"}, edges, 4);
        else        chk(edges == 6 + 3*n, {tag, " R11 done edge"}, edges, 6 + 3*n);
        // R9: done holds while start high
        repeat (3) @(negedge clk);
        chk(done == 1'b1, {tag, " R9 done held"}, int'(done), 1);
        start = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(done == 1'b0, {tag, " R9 done released"}, int'(done), 0);
        // R3: write count and placement
        chk(wr_cnt == n, {tag, " R3 write count"}, wr_cnt, n);
        chk(stray == 0, {tag, " R3 stray accesses"}, stray, 0);
        chk(mem[2 + 2*n] == 8'h3C, {tag, " R3 byte past output"}, int'(mem[2 + 2*n]), 'h3C);
        // R4..R7: output pixels
        mism = 0; first_a = 0; first_e = 0;
        for (int k = 0; k < n; k++) begin
            int e = exp_pix(img[k], lo, s);
            if (int'(mem[2 + n + k]) != e) begin
                if (mism == 0) begin first_a = mem[2 + n + k]; first_e = e; end
                mism++;
            end
        end
        chk(mism == 0, {tag, " R4 output pixels"}, first_a, first_e);
        // R10 / R2: input region untouched
        inchg = 0;
        for (int a = 0; a < 2 + n; a++) if (mem[a] !== snap[a]) inchg++;
        chk(inchg == 0, {tag, " R10 input preserved"}, inchg, 0);
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd2468);
        rd_data = '0;
        for (int a = 0; a < MEM_D; a++) mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        // R1
        chk(done == 0 && mem_en == 0 && mem_we == 0, "R1 in reset", int'({done, mem_en, mem_we}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0 && mem_en == 0 && mem_we == 0, "R1 after reset", int'({done, mem_en, mem_we}), 0);

        run_image(3, 2, 40, 30, 0, "R2 small");
        run_image(5, 4, 77, 0, 1, "R5 flat");
        run_image(8, 8, 0, 255, 2, "R6 full range");
        run_image(6, 5, 0, 100, 0, "R7 saturating");
        run_image(0, 9, 0, 0, 0, "R8 no cols");
        run_image(7, 0, 0, 0, 0, "R8 no rows");
        run_image(1, 1, 200, 0, 0, "R5 single");
        run_image(128, 8, 10, 200, 0, "R2 wide");
        for (int t = 0; t < 6; t++) begin
            int c = 1 + int'($urandom % 24);
            int r = 1 + int'($urandom % 24);
            int b = int'($urandom % 200);
            int sp = int'($urandom % (256 - b));
            run_image(c, r, b, sp, 0, "R9 back-to-back random");
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", 190000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule